// File: doc/BRIEF.md
# I2C Target with Byte-Split 16-bit Registers

This block is an I2C target (slave) that serves a small array of 16-bit registers over a byte-wide bus. Each register is visible as two adjacent byte addresses. The even address holds the upper half and the odd address holds the lower half, so a controller reads or writes a whole register as a consecutive pair. The block never drives SCL. It only pulls SDA low through an open-drain enable, and the enable is released to let SDA float high.

SCL and SDA pass through a synchroniser into the system clock domain. START and STOP are detected from the synchronised lines. The target compares the first byte of a transfer against its 7-bit device address. In a write transfer, the first byte after the address loads a byte pointer, and every later byte is stored at that pointer. A read transfer returns bytes starting at the current pointer. The pointer advances after every data byte in both directions.

Top module: `i2c_byte_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP returns the target to idle at any point, and a START (first or repeated) returns it to address matching at any point. In both cases a partly received byte is discarded.
- R2: The byte after START holds the 7-bit address followed by the direction bit, MSB first (direction 1 = read, 0 = write). When the address equals DEV_ADDR, the target holds SDA low for the whole 9th clock.
- R3: When the address does not match, the target does not acknowledge. It then drives nothing and writes nothing until the next START.
- R4: In a write transfer, the first byte after the address loads the pointer from its low PTR_W bits. Every later byte is stored at the pointer. The target acknowledges each of these bytes.
- R5: Byte address 2k selects bits 15:8 of register k, and byte address 2k+1 selects bits 7:0. A byte write leaves the other half of the register unchanged.
- R6: The pointer increments by one after each data byte written or read, and wraps modulo 2*NUM_REGS. It keeps its value across transfers.
- R7: In a read transfer, the target sends the byte at the pointer MSB first, with each bit valid while SCL is high.
- R8: An acknowledge (SDA low) from the controller after a read byte makes the target send the next byte. A NACK (SDA high) releases SDA, and the target ignores the bus until the next START.
- R9: After reset, SDA is released, all registers read 0 and the pointer is 0.
- R10: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can fall on the same bus position: bus-condition detection and byte reception. A START or STOP can arrive while a byte is half shifted in. The bench provokes this by cutting a pointer-loaded write after four data bits with a STOP in one case and with a repeated START in another. The result is judged by reading the affected registers back: the partial byte must never land in them. A second overlap is the controller's NACK against the fetch of the next read byte. This is judged by clocking further bits after the NACK and requiring every one of them to read high, with the drive enable held low on every clock.

// File: rtl/i2c_byte_target_pkg.sv
`timescale 1ns/1ps
package i2c_byte_target_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK, ST_TXW
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic         scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_q  <= scl_ff[MSB];
      sda_q  <= sda_ff[MSB];
    end
  end

  assign scl_o   = scl_ff[MSB];
  assign sda_o   = sda_ff[MSB];
  assign start_o = scl_q & scl_o & sda_q & ~sda_o;
  assign stop_o  = scl_q & scl_o & ~sda_q & sda_o;
  assign rise_o  = ~scl_q & scl_o;
  assign fall_o  = scl_q & ~scl_o;
endmodule

// File: rtl/i2c_byte_regs.sv
`timescale 1ns/1ps
module i2c_byte_regs #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = $clog2(NUM_REGS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic [7:0]       rd_byte_o
);
  localparam int IDX_W = PTR_W - 1;

  logic [15:0] regs [NUM_REGS];
  logic [15:0] rd_word;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs[g] <= '0;
      end else if (wr_en_i && wr_ptr_i[PTR_W-1:1] == IDX_W'(g)) begin
        if (wr_ptr_i[0]) regs[g][7:0]  <= wr_byte_i;
        else             regs[g][15:8] <= wr_byte_i;
      end
    end
  end

  assign rd_word   = regs[rd_ptr_i[PTR_W-1:1]];
  assign rd_byte_o = rd_ptr_i[0] ? rd_word[7:0] : rd_word[15:8];

  AST_EVEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ptr_i[0]) |=> (regs[$past(wr_ptr_i[PTR_W-1:1])][15:8] == $past(wr_byte_i)
      && regs[$past(wr_ptr_i[PTR_W-1:1])][7:0] == $past(rd_word[7:0]))); // R5
  AST_ODD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ptr_i[0] && wr_ptr_i == rd_ptr_i) |=> (regs[$past(wr_ptr_i[PTR_W-1:1])][7:0] == $past(wr_byte_i)
      && regs[$past(wr_ptr_i[PTR_W-1:1])][15:8] == $past(rd_word[15:8]))); // R5
endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm
  import i2c_byte_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [7:0]       rd_byte_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_byte_o,
  output logic             sda_oe_o
);
  tgt_state_e st;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       is_addr, rw, ptr_set;

  assign wr_byte_o = shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      is_addr  <= 1'b0;
      rw       <= 1'b0;
      ptr_set  <= 1'b0;
      ptr_o    <= '0;
      wr_en_o  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (wr_en_o) ptr_o <= ptr_o + 1'b1;
      if (start_i) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
        ptr_set  <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (rise_i) begin
              shreg <= {shreg[6:0], sda_s_i};
              cnt   <= cnt + 1'b1;
            end else if (fall_i && cnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                st       <= ST_ACK;
                sda_oe_o <= 1'b1;
                is_addr  <= 1'b1;
                rw       <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (rise_i) begin
              cnt <= 4'd9;
            end else if (fall_i && cnt == 4'd9) begin
              cnt <= '0;
              if (is_addr && rw) begin
                st       <= ST_TX;
                shreg    <= rd_byte_i;
                sda_oe_o <= ~rd_byte_i[7];
              end else begin
                st       <= ST_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (rise_i) begin
              shreg <= {shreg[6:0], sda_s_i};
              cnt   <= cnt + 1'b1;
            end else if (fall_i && cnt == 4'd8) begin
              if (!ptr_set) begin
                ptr_o   <= shreg[PTR_W-1:0];
                ptr_set <= 1'b1;
              end else begin
                wr_en_o <= 1'b1;
              end
              st       <= ST_ACK;
              is_addr  <= 1'b0;
              sda_oe_o <= 1'b1;
            end
          end
          ST_TX: begin
            if (rise_i) begin
              cnt <= cnt + 1'b1;
            end else if (fall_i) begin
              if (cnt == 4'd8) begin
                st       <= ST_MACK;
                sda_oe_o <= 1'b0;
                ptr_o    <= ptr_o + 1'b1;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
              end
            end
          end
          ST_MACK: begin
            if (rise_i) begin
              if (sda_s_i) begin
                st <= ST_IDLE;
              end else begin
                st    <= ST_TXW;
                shreg <= rd_byte_i;
              end
            end
          end
          ST_TXW: begin
            if (fall_i) begin
              st       <= ST_TX;
              cnt      <= '0;
              sda_oe_o <= ~shreg[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st == ST_ADDR && cnt == 4'd0)); // R1
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (st == ST_IDLE && !sda_oe_o)); // R1
  AST_ADDR_MATCH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ADDR && fall_i && cnt == 4'd8 && shreg[7:1] == DEV_ADDR && !start_i && !stop_i)
      |=> (st == ST_ACK && sda_oe_o)); // R2
  AST_NO_MATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ADDR && fall_i && cnt == 4'd8 && shreg[7:1] != DEV_ADDR && !start_i && !stop_i)
      |=> (st == ST_IDLE && !sda_oe_o)); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_o == $past(ptr_o) + 1'b1); // R6
  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_MACK && rise_i && sda_s_i && !start_i && !stop_i) |=> (st == ST_IDLE && !sda_oe_o)); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s_i); // R10
endmodule

// File: rtl/i2c_byte_target.sv
`timescale 1ns/1ps
module i2c_byte_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int PTR_W = $clog2(NUM_REGS) + 1;

  logic             scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_byte, rd_byte;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .scl_o  (scl_s),
    .sda_o  (sda_s),
    .start_o(start_evt),
    .stop_o (stop_evt),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_s_i  (scl_s),
    .sda_s_i  (sda_s),
    .start_i  (start_evt),
    .stop_i   (stop_evt),
    .rise_i   (scl_rise),
    .fall_i   (scl_fall),
    .rd_byte_i(rd_byte),
    .ptr_o    (ptr),
    .wr_en_o  (wr_en),
    .wr_byte_o(wr_byte),
    .sda_oe_o (sda_oe_o)
  );

  i2c_byte_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_ptr_i (ptr),
    .wr_byte_i(wr_byte),
    .rd_ptr_i (ptr),
    .rd_byte_o(rd_byte)
  );
endmodule

// File: tb/test_i2c_byte_target.sv
`timescale 1ns/1ps
module test_i2c_byte_target;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int         NREG = 8;
  localparam int         NBYTE = 2 * NREG;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  int   n_chk = 0, n_err = 0;
  int   hl_viol = 0, quiet_viol = 0;
  logic quiet = 1'b0, prev_scl = 1'b1, prev_oe = 1'b0, done = 1'b0;
  logic [15:0] mdl [NREG];
  int   mptr = 0;

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  i2c_byte_target #(.DEV_ADDR(ADDR), .NUM_REGS(NREG), .SYNC_STAGES(2)) i_i2c_byte_target (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe)
  );

  // per-clock bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl && prev_scl && sda_oe !== prev_oe) hl_viol++;
      if (quiet && sda_oe !== 1'b0) quiet_viol++;
    end
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic w(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int p);
    logic [15:0] r;
    r = mdl[(p % NBYTE) / 2];
    return (p % 2 == 0) ? r[15:8] : r[7:0];
  endfunction

  function automatic void mwrite(int p, logic [7:0] b);
    int q;
    q = p % NBYTE;
    if (q % 2 == 0) mdl[q/2][15:8] = b;
    else            mdl[q/2][7:0]  = b;
  endfunction

  task automatic clk_bit(input logic v, output logic s);
    sda_m = v; w(10);
    scl = 1'b1; w(10);
    s = sda_bus; w(10);
    scl = 1'b0; w(10);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(10);
    scl = 1'b1; w(10);
    sda_m = 1'b0; w(10);
    scl = 1'b0; w(10);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(10);
    scl = 1'b1; w(10);
    sda_m = 1'b1; w(20);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  // write transaction: pointer then bytes
  task automatic wr_txn(input logic [7:0] p, input logic [7:0] d [], input string req);
    logic a;
    bus_start;
    send({ADDR, 1'b0}, a); chk("R2 write address ack", a, 1'b1);
    send(p, a);            chk("R4 pointer ack", a, 1'b1);
    mptr = p % NBYTE;
    foreach (d[i]) begin
      send(d[i], a); chk({req, " data ack"}, a, 1'b1);
      mwrite(mptr, d[i]);
      mptr = (mptr + 1) % NBYTE;
    end
    bus_stop;
  endtask

  // pointer write, repeated START, read n bytes (last NACKed)
  task automatic rd_txn(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] b;
    bus_start;
    send({ADDR, 1'b0}, a);
    send(p, a);
    mptr = p % NBYTE;
    bus_start;
    send({ADDR, 1'b1}, a); chk("R2 read address ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      chk(req, b, mbyte(mptr));
      mptr = (mptr + 1) % NBYTE;
    end
    bus_stop;
  endtask

  initial begin
    logic a, s;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    w(5);
    rst_n = 1'b1;
    w(5);
    chk("R9 SDA released after reset", sda_oe, 1'b0);

    // R9: registers zero, pointer zero -> read without pointer returns byte 0
    bus_start;
    send({ADDR, 1'b1}, a); chk("R2 read ack", a, 1'b1);
    recv(1'b0, b); chk("R9 reset contents and pointer", b, 8'h00);
    bus_stop;

    // R4 R5: write even/odd pair, read back high then low
    wr_txn(8'h02, '{8'hA5, 8'h3C}, "R4");
    rd_txn(8'h02, 2, "R5 even high odd low");

    // R6: odd start, crossing register boundary
    wr_txn(8'h05, '{8'h11, 8'h22, 8'h33}, "R4");
    rd_txn(8'h03, 4, "R6 increment across registers");

    // R6: wrap of the byte pointer
    wr_txn(8'h0F, '{8'h77, 8'h88}, "R6");
    rd_txn(8'h0E, 3, "R6 pointer wrap");

    // R7: read with no pointer continues at current pointer
    rd_txn(8'h00, 2, "R7 read bytes MSB first");
    bus_start;
    send({ADDR, 1'b1}, a);
    recv(1'b0, b); chk("R7 read continues at pointer", b, mbyte(mptr));
    mptr = (mptr + 1) % NBYTE;
    bus_stop;

    // R3: mismatching address, following bytes ignored
    bus_start;
    send({7'h2D, 1'b0}, a); chk("R3 no ack on mismatch", a, 1'b0);
    quiet = 1'b1;
    send(8'h00, a); chk("R3 ignored byte not acked", a, 1'b0);
    send(8'hFF, a); chk("R3 ignored byte not acked", a, 1'b0);
    bus_stop;
    quiet = 1'b0;
    rd_txn(8'h00, 2, "R3 registers unchanged");

    // R8: NACK releases bus, extra clocks read all ones
    bus_start;
    send({ADDR, 1'b1}, a);
    recv(1'b0, b); chk("R8 byte before NACK", b, mbyte(mptr));
    mptr = (mptr + 1) % NBYTE;
    quiet = 1'b1;
    recv(1'b0, b); chk("R8 bus released after NACK", b, 8'hFF);
    quiet = 1'b0;
    bus_stop;

    // R1: STOP in the middle of a data byte
    bus_start;
    send({ADDR, 1'b0}, a);
    send(8'h04, a);
    mptr = 4;
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_stop;
    bus_start;
    send({ADDR, 1'b1}, a); chk("R1 target answers after STOP", a, 1'b1);
    recv(1'b1, b); chk("R1 partial byte discarded (stop)", b, mbyte(4));
    recv(1'b0, b); chk("R1 next byte after stop abort", b, mbyte(5));
    bus_stop;

    // R1: repeated START in the middle of a data byte
    bus_start;
    send({ADDR, 1'b0}, a);
    send(8'h06, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_start;
    send({ADDR, 1'b1}, a); chk("R1 address match after repeated START", a, 1'b1);
    recv(1'b0, b); chk("R1 partial byte discarded (restart)", b, mbyte(6));
    bus_stop;

    chk("R10 drive changes only with SCL low", 16'(hl_viol), 16'd0);
    chk("R3 R8 no drive while ignoring bus", 16'(quiet_viol), 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule